// File: doc/BRIEF.md
# Spawn-Join Virtual Thread Dispatcher

This block sits between a master core and a pool of lightweight thread control units (TCUs). The master opens a parallel section by presenting an inclusive range of virtual thread IDs. The dispatcher latches the range and places it on a shared broadcast bus that every TCU can see. In the same step it gives each TCU its first ID, which is the low bound plus that TCU's own index.

After that, the TCUs run independently. A TCU that finishes a thread raises its request. It then receives the next value of a shared ID counter, which works as an atomic fetch-and-add of one. When several TCUs ask in the same cycle, each receives a different consecutive value, and lower indices receive the smaller values. A TCU that draws a value above the high bound expires at once and does not wait. When every TCU has expired, the join completes: the master gets a single-cycle completion pulse and the dispatcher goes idle.

Spawns do not nest. A spawn request made while a section is open is not acknowledged. The master must keep the request held until the dispatcher is idle again.

Top module: `vt_dispatch`

## Requirements
- R1: After reset, `busy`, `spawn_ack`, `join_done`, every `tcu_gnt` bit and every `tcu_exp` bit are 0.
- R2: When `spawn_req` is high at a clock edge while `busy` is low, the request is accepted. In the following cycle `spawn_ack` is high for exactly one cycle, `busy` is high, and `bcast_lo`/`bcast_hi` show the accepted bounds.
- R3: In the cycle after acceptance, every TCU i with lo+i <= hi shows `tcu_gnt[i]`=1 with ID lo+i. The ID of TCU i is carried on bits [i*IDW +: IDW] of `tcu_vid`.
- R4: In that same cycle, every TCU i with lo+i > hi shows `tcu_exp[i]`=1 and no grant.
- R5: The shared counter starts at lo+NTCU. A request from a live TCU is answered in the next cycle with the current counter value, and the counter then advances by one for each request.
- R6: If k live TCUs request in the same cycle, they receive the k consecutive counter values in ascending TCU-index order, and the counter advances by k.
- R7: A TCU whose drawn value exceeds hi does not receive a grant. Instead it raises `tcu_exp`, which stays high until the next spawn is accepted.
- R8: In the cycle after the last TCU expires, `join_done` is high for exactly one cycle and `busy` is low from that cycle on.
- R9: A `spawn_req` made while `busy` is high receives no acknowledgement and changes neither the broadcast bounds nor the dispensing of IDs.
- R10: Requests from TCUs that have expired, and any requests made while idle, produce no grant.
- R11: Over one spawn, every ID in [lo, hi] is granted exactly once and no ID outside that range is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spawn_req | input | 1 | Master asks to open a spawn; held until acknowledged |
| spawn_lo | input | IDW | Lowest virtual ID of the requested range |
| spawn_hi | input | IDW | Highest virtual ID of the requested range |
| spawn_ack | output | 1 | One-cycle pulse: spawn accepted |
| busy | output | 1 | A spawn is open |
| join_done | output | 1 | One-cycle pulse: all TCUs expired |
| bcast_lo | output | IDW | Broadcast low bound of the open spawn |
| bcast_hi | output | IDW | Broadcast high bound of the open spawn |
| tcu_req | input | NTCU | Per-TCU request for a next ID |
| tcu_gnt | output | NTCU | Per-TCU one-cycle grant, with the ID on tcu_vid |
| tcu_exp | output | NTCU | Per-TCU expired flag |
| tcu_vid | output | NTCU*IDW | Per-TCU granted virtual ID, packed by index |

## Verification
Two cases can occur in the same cycle: several TCUs fetching at once, and the high bound falling inside the group of consecutive values those TCUs draw. The lower-indexed TCUs then receive grants while the higher-indexed ones expire, all at the same edge. The bench provokes this with random multi-TCU request patterns over short ranges, so that the bound is often crossed in the middle of a group. It judges each TCU against a model counter that hands out values in index order. A spawn request held during an open section is checked at the same edge as those fetches, to confirm it is refused.

// File: rtl/vt_dispatch.sv
module vt_dispatch #(
  parameter int NTCU = 6,
  parameter int IDW  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 spawn_req,
  input  logic [IDW-1:0]       spawn_lo,
  input  logic [IDW-1:0]       spawn_hi,
  output logic                 spawn_ack,
  output logic                 busy,
  output logic                 join_done,
  output logic [IDW-1:0]       bcast_lo,
  output logic [IDW-1:0]       bcast_hi,
  input  logic [NTCU-1:0]      tcu_req,
  output logic [NTCU-1:0]      tcu_gnt,
  output logic [NTCU-1:0]      tcu_exp,
  output logic [NTCU*IDW-1:0]  tcu_vid
);
  localparam int RW = $clog2(NTCU + 1);
  localparam int CW = IDW + RW + 2;

  logic            open_q;
  logic [IDW-1:0]  lo_q, hi_q;
  logic [CW-1:0]   ctr_q;
  logic [IDW-1:0]  vid_q [NTCU];
  logic [NTCU-1:0] gnt_q, exp_q;

  wire             take  = spawn_req & ~open_q;
  wire [NTCU-1:0]  asker = tcu_req & ~exp_q & {NTCU{open_q}};
  wire [CW-1:0]    hi_cw = CW'(hi_q);
  wire [CW-1:0]    sp_hi = CW'(spawn_hi);

  logic [RW-1:0]   rank [NTCU];
  logic [RW-1:0]   taken;
  logic [CW-1:0]   draw [NTCU];
  logic [CW-1:0]   first[NTCU];

  always_comb begin
    taken = '0;
    for (int i = 0; i < NTCU; i++) begin
      rank[i]  = taken;
      taken    = taken + RW'(asker[i]);
      draw[i]  = ctr_q + CW'(rank[i]);
      first[i] = CW'(spawn_lo) + CW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      spawn_ack <= 1'b0;
      join_done <= 1'b0;
      lo_q      <= '0;
      hi_q      <= '0;
      ctr_q     <= '0;
      gnt_q     <= '0;
      exp_q     <= '0;
      for (int i = 0; i < NTCU; i++) vid_q[i] <= '0;
    end else begin
      spawn_ack <= take;
      join_done <= 1'b0;
      gnt_q     <= '0;
      if (take) begin
        open_q <= 1'b1;
        lo_q   <= spawn_lo;
        hi_q   <= spawn_hi;
        ctr_q  <= CW'(spawn_lo) + CW'(NTCU);
        for (int i = 0; i < NTCU; i++) begin
          vid_q[i] <= IDW'(first[i]);
          gnt_q[i] <= first[i] <= sp_hi;
          exp_q[i] <= first[i] >  sp_hi;
        end
      end else if (open_q) begin
        if (&exp_q) begin
          join_done <= 1'b1;
          open_q    <= 1'b0;
        end else begin
          ctr_q <= ctr_q + CW'(taken);
          for (int i = 0; i < NTCU; i++) begin
            if (asker[i]) begin
              if (draw[i] <= hi_cw) begin
                gnt_q[i] <= 1'b1;
                vid_q[i] <= IDW'(draw[i]);
              end else begin
                exp_q[i] <= 1'b1;
              end
            end
          end
        end
      end
    end
  end

  assign busy     = open_q;
  assign bcast_lo = lo_q;
  assign bcast_hi = hi_q;
  assign tcu_gnt  = gnt_q;
  assign tcu_exp  = exp_q;

  for (genvar g = 0; g < NTCU; g++) begin : g_vid
    assign tcu_vid[g*IDW +: IDW] = vid_q[g];
  end
endmodule

// File: rtl/vt_dispatch_chk.sv
module vt_dispatch_chk #(
  parameter int NTCU = 6,
  parameter int IDW  = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic                spawn_ack,
  input logic                busy,
  input logic                join_done,
  input logic [IDW-1:0]      bcast_lo,
  input logic [IDW-1:0]      bcast_hi,
  input logic [NTCU-1:0]     tcu_gnt,
  input logic [NTCU-1:0]     tcu_exp,
  input logic [NTCU*IDW-1:0] tcu_vid
);
  AST_ACK_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    spawn_ack |-> busy && !$past(busy)); // R2
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    spawn_ack |=> !spawn_ack); // R2
  AST_GNT_NOT_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    (tcu_gnt & tcu_exp) == '0); // R7
  AST_GNT_WHILE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (tcu_gnt != '0) |-> busy); // R10
  AST_JOIN_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    join_done |-> !busy && $past(busy) && (&tcu_exp)); // R8
  AST_JOIN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    join_done |=> !join_done); // R8
  AST_BOUNDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !spawn_ack |-> $stable(bcast_lo) && $stable(bcast_hi)); // R9
  for (genvar g = 0; g < NTCU; g++) begin : g_rng
    AST_GNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      tcu_gnt[g] |-> tcu_vid[g*IDW +: IDW] >= bcast_lo
                  && tcu_vid[g*IDW +: IDW] <= bcast_hi); // R11
  end
endmodule

bind vt_dispatch vt_dispatch_chk #(.NTCU(NTCU), .IDW(IDW)) u_chk (
  .clk(clk), .rst_n(rst_n), .spawn_ack(spawn_ack), .busy(busy),
  .join_done(join_done), .bcast_lo(bcast_lo), .bcast_hi(bcast_hi),
  .tcu_gnt(tcu_gnt), .tcu_exp(tcu_exp), .tcu_vid(tcu_vid));

// File: tb/vt_dispatch_bench.sv
module vt_dispatch_bench;
  localparam int N   = 6;
  localparam int IDW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spawn_req = 1'b0;
  logic [IDW-1:0] spawn_lo = '0, spawn_hi = '0;
  logic spawn_ack, busy, join_done;
  logic [IDW-1:0] bcast_lo, bcast_hi;
  logic [N-1:0] tcu_req = '0;
  logic [N-1:0] tcu_gnt, tcu_exp;
  logic [N*IDW-1:0] tcu_vid;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  vt_dispatch #(.NTCU(N), .IDW(IDW)) u_vt_dispatch (
    .clk(clk), .rst_n(rst_n), .spawn_req(spawn_req), .spawn_lo(spawn_lo),
    .spawn_hi(spawn_hi), .spawn_ack(spawn_ack), .busy(busy),
    .join_done(join_done), .bcast_lo(bcast_lo), .bcast_hi(bcast_hi),
    .tcu_req(tcu_req), .tcu_gnt(tcu_gnt), .tcu_exp(tcu_exp), .tcu_vid(tcu_vid));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int vid_of(input int i);
    return int'(tcu_vid[i*IDW +: IDW]);
  endfunction

  function automatic bit first_live(input int lo, input int hi, input int i);
    return (lo + i) <= hi;
  endfunction

  int seen [int];

  task automatic run_spawn(input int lo, input int hi, input int pct, input bit poke);
    bit live [N];
    int nxt;
    int guard;
    bit any;
    seen.delete();
    spawn_lo = IDW'(lo); spawn_hi = IDW'(hi); spawn_req = 1'b1;
    @(negedge clk);
    spawn_req = 1'b0;
    check(spawn_ack == 1'b1, "R2 ack", int'(spawn_ack), 1);
    check(busy == 1'b1, "R2 busy", int'(busy), 1);
    check(int'(bcast_lo) == lo && int'(bcast_hi) == hi, "R2 bounds", int'(bcast_lo), lo);
    for (int i = 0; i < N; i++) begin
      live[i] = first_live(lo, hi, i);
      if (live[i]) begin
        check(tcu_gnt[i] && vid_of(i) == lo + i, "R3 first id", vid_of(i), lo + i);
        seen[lo + i] = 1;
      end else begin
        check(tcu_exp[i] && !tcu_gnt[i], "R4 early expire", int'(tcu_exp[i]), 1);
      end
    end
    nxt = lo + N;
    guard = 0;
    any = 0;
    for (int i = 0; i < N; i++) any |= live[i];
    while (any && guard < 2000) begin
      int rk;
      bit asked [N];
      guard++;
      for (int i = 0; i < N; i++) begin
        asked[i] = live[i] && (($urandom % 100) < pct);
        tcu_req[i] = asked[i] || (!live[i] && ($urandom % 2 == 0));
      end
      if (poke && guard == 1) begin
        spawn_req = 1'b1; spawn_lo = IDW'(lo + 100); spawn_hi = IDW'(hi + 100);
      end
      @(negedge clk);
      if (poke && guard == 1) begin
        check(spawn_ack == 1'b0, "R9 no nested ack", int'(spawn_ack), 0);
        check(int'(bcast_lo) == lo && int'(bcast_hi) == hi, "R9 bounds kept", int'(bcast_lo), lo);
        spawn_req = 1'b0;
      end
      rk = 0;
      for (int i = 0; i < N; i++) begin
        if (asked[i]) begin
          int v = nxt + rk;
          rk++;
          if (v <= hi) begin
            check(tcu_gnt[i] && vid_of(i) == v, "R5 R6 fetch order", vid_of(i), v);
            check(!seen.exists(v), "R11 unique id", v, -1);
            seen[v] = 1;
          end else begin
            check(tcu_exp[i] && !tcu_gnt[i], "R7 expire on overflow", int'(tcu_exp[i]), 1);
            live[i] = 0;
          end
        end else begin
          check(!tcu_gnt[i], "R10 no unasked grant", int'(tcu_gnt[i]), 0);
        end
      end
      nxt += rk;
      tcu_req = '0;
      any = 0;
      for (int i = 0; i < N; i++) any |= live[i];
      if (any) check(busy == 1'b1 && join_done == 1'b0, "R8 open while live", int'(busy), 1);
    end
    @(negedge clk);
    check(join_done == 1'b1 && busy == 1'b0, "R8 join pulse", int'(join_done), 1);
    check(seen.num() == (hi >= lo ? hi - lo + 1 : 0), "R11 full cover", seen.num(), hi - lo + 1);
    @(negedge clk);
    check(join_done == 1'b0, "R8 pulse width", int'(join_done), 0);
  endtask

  initial begin
    #900000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check(!busy && !spawn_ack && !join_done, "R1 reset ctl", int'(busy), 0);
    check(tcu_gnt == '0 && tcu_exp == '0, "R1 reset tcu", int'(tcu_gnt), 0);
    rst_n = 1'b1;
    tcu_req = '1;
    @(negedge clk);
    check(tcu_gnt == '0, "R10 idle request", int'(tcu_gnt), 0);
    tcu_req = '0;
    run_spawn(10, 9 + N, 100, 1'b1);
    run_spawn(40, 42, 100, 1'b0);
    run_spawn(50, 50, 50, 1'b0);
    run_spawn(60, 59, 50, 1'b0);
    run_spawn(100, 160, 100, 1'b1);
    for (int t = 0; t < 25; t++) begin
      int lo = int'($urandom % 3000);
      int hi = lo + int'($urandom % 50) - 2;
      run_spawn(lo, hi, 20 + int'($urandom % 80), t[0]);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule